// File: doc/BRIEF.md
# Configurable UART Framing Transmitter

This block turns one byte at a time into an asynchronous serial frame. The frame shape comes from a packed line-control word: the data width is 5 to 8 bits, an optional parity bit can be even or odd, and one or two stop bits follow. A baud generator with an integer and a 3-bit fractional divisor sets how many reference clocks each bit lasts. Software-side logic writes a byte with a one-cycle strobe. Two flags report that the holding buffer and the shifter are empty, and a one-cycle pulse marks the end of each frame so that it can feed a transmit interrupt source.

The frame format and the bit period are sampled when a frame starts. Changes to line control or to the divisors while a frame is on the line only apply to the next frame. While the integer divisor is zero the generator stays idle. A byte that has been written waits in the holding register until the divisor becomes nonzero.

Top module: `uart_frame_tx`

## Requirements
- R1: After synchronous reset, `txd` is 1, `buf_empty` and `xmit_empty` are both 1 (the status value 0x6 with bit 1 and bit 2 set), and `tx_done` is 0.
- R2: The number of data bits is `line_ctrl[1:0]` + 5. Data bits go out least significant bit first, right after the start bit.
- R3: When `line_ctrl[5]` is 1, a parity bit follows the data. It is even parity (data ones plus parity give an even count) when `line_ctrl[3]` is 1, and odd parity otherwise. When `line_ctrl[5]` is 0 there is no parity bit.
- R4: Each frame is one start bit at 0, then the data, then the optional parity, then the stop bits at 1. There are two stop bits when `line_ctrl[2]` is 1 and one otherwise.
- R5: Each bit lasts 16·`baud_div` + `baud_frac` + 16 clock cycles. A frame of N bits holds the line for exactly N such periods, measured from the start bit until both empty flags rise.
- R6: While `baud_div` is zero, no frame starts and `txd` stays 1. A byte that was written is kept and goes out once the divisor becomes nonzero.
- R7: An accepted write clears both empty flags on the next cycle. Both flags return to 1 in the cycle the last stop bit ends. `tx_done` is high for exactly that one cycle.
- R8: A write strobe while the empty flags are 0 is ignored. No extra frame is sent for it.
- R9: Line control and the divisors are captured at the start of a frame. Changing them mid-frame changes neither the current frame's format nor its timing, only the next frame's.
- R10: The line is high whenever no frame is being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| line_ctrl | input | 8 | Packed frame format: [1:0] width code, [2] two stop bits, [3] even parity, [5] parity enable |
| baud_div | input | DIV_W (16) | Integer baud divisor; zero keeps the generator idle |
| baud_frac | input | FRAC_W (3) | Fractional extra clocks per bit, 0 to 7 |
| tx_wr | input | 1 | One-cycle byte write strobe |
| tx_byte | input | 8 | Byte to transmit |
| txd | output | 1 | Serial output line, idle high |
| buf_empty | output | 1 | Holding buffer empty flag |
| xmit_empty | output | 1 | Transmitter empty flag |
| tx_done | output | 1 | One-cycle pulse at the end of each frame |

## Verification
The bench walks frames of every data width, with no parity, even parity and odd parity, and with one or two stop bits. It uses several fractional values, so a period that is off by one clock, or that ignores the fraction, shows up as flags rising one or more cycles away from the N·P boundary. A design that stored a mid-frame write would send a second frame, and the bench watches the line for several frame times to catch it. A design that applied new settings mid-frame would stretch the running frame. A zero divisor is held for hundreds of cycles to show that nothing leaves the line, and the byte written during that time must then go out intact once the divisor is set.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_MAX  = 8;
  localparam int FRAME_MAX = 1 + DATA_MAX + 1 + 2;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);
  localparam int LC_W      = 8;

  // line-control field positions
  localparam int LC_WIDTH_LSB = 0;
  localparam int LC_STOP2     = 2;
  localparam int LC_EVEN      = 3;
  localparam int LC_PAR_EN    = 5;

  typedef struct packed {
    logic [3:0] data_bits;
    logic       par_en;
    logic       par_even;
    logic       stop2;
  } frame_cfg_t;
endpackage

// File: rtl/uart_lcr_decode.sv
module uart_lcr_decode
  import uart_tx_pkg::*;
(
  input  logic [LC_W-1:0] line_ctrl,
  output frame_cfg_t      cfg
);
  logic unused_lc_bits;
  assign unused_lc_bits = ^{line_ctrl[7:6], line_ctrl[4]};

  always_comb begin
    cfg.data_bits = 4'd5 + {2'b00, line_ctrl[LC_WIDTH_LSB +: 2]};
    cfg.par_en    = line_ctrl[LC_PAR_EN];
    cfg.par_even  = line_ctrl[LC_EVEN];
    cfg.stop2     = line_ctrl[LC_STOP2];
  end
endmodule

// File: rtl/uart_frame_build.sv
module uart_frame_build
  import uart_tx_pkg::*;
(
  input  frame_cfg_t           cfg,
  input  logic [DATA_MAX-1:0]  data,
  output logic [FRAME_MAX-1:0] bits,
  output logic [LEN_W-1:0]     len
);
  logic [DATA_MAX-1:0] mask;
  logic [DATA_MAX-1:0] kept;
  logic                par_bit;
  logic [LEN_W-1:0]    par_pos;

  always_comb begin
    for (int i = 0; i < DATA_MAX; i++) begin
      mask[i] = (i < int'(cfg.data_bits));
    end
    kept    = data & mask;
    par_bit = cfg.par_even ? (^kept) : ~(^kept);
    par_pos = LEN_W'(1) + LEN_W'(cfg.data_bits);

    // unused upper positions stay at 1 so they serve as stop/idle
    bits    = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (mask[i]) bits[1 + i] = data[i];
    end
    if (cfg.par_en) bits[par_pos] = par_bit;

    len = LEN_W'(2) + LEN_W'(cfg.data_bits) + LEN_W'(cfg.par_en) + LEN_W'(cfg.stop2);
  end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DIV_W-1:0]  div,
  input  logic [FRAC_W-1:0] frac,
  output logic              tick
);
  localparam int CNT_W = DIV_W + 5;

  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign period = CNT_W'({div, 4'b0000}) + CNT_W'(frac) + CNT_W'(16);
  assign last   = (cnt_q == period - CNT_W'(1));
  assign tick   = run && last;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [FRAME_MAX-1:0] frame_in,
  input  logic [LEN_W-1:0]     len_in,
  input  logic [DIV_W-1:0]     div_in,
  input  logic [FRAC_W-1:0]    frac_in,
  input  logic                 tick,
  output logic                 txd,
  output logic                 busy,
  output logic                 frame_end,
  output logic [DIV_W-1:0]     div_q,
  output logic [FRAC_W-1:0]    frac_q
);
  logic [FRAME_MAX-1:0] sh_q;
  logic [LEN_W-1:0]     left_q;
  logic                 busy_q;
  logic                 txd_q;

  assign busy      = busy_q;
  assign txd       = txd_q;
  assign frame_end = busy_q && tick && (left_q == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      div_q  <= '0;
      frac_q <= '0;
    end else if (start) begin
      sh_q   <= frame_in;
      txd_q  <= frame_in[0];
      left_q <= len_in;
      busy_q <= 1'b1;
      div_q  <= div_in;
      frac_q <= frac_in;
    end else if (busy_q && tick) begin
      if (left_q == LEN_W'(1)) begin
        busy_q <= 1'b0;
        txd_q  <= 1'b1;
      end else begin
        sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
        txd_q  <= sh_q[1];
        left_q <= left_q - LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LC_W-1:0]     line_ctrl,
  input  logic [DIV_W-1:0]    baud_div,
  input  logic [FRAC_W-1:0]   baud_frac,
  input  logic                tx_wr,
  input  logic [DATA_MAX-1:0] tx_byte,
  output logic                txd,
  output logic                buf_empty,
  output logic                xmit_empty,
  output logic                tx_done
);
  frame_cfg_t           cfg;
  logic [FRAME_MAX-1:0] frame_bits;
  logic [LEN_W-1:0]     frame_len;
  logic [DATA_MAX-1:0]  hold_q;
  logic                 pending_q;
  logic                 buf_empty_q;
  logic                 xmit_empty_q;
  logic                 done_q;
  logic                 accept;
  logic                 start;
  logic                 busy;
  logic                 frame_end;
  logic                 tick;
  logic [DIV_W-1:0]     div_run;
  logic [FRAC_W-1:0]    frac_run;

  uart_lcr_decode u_dec (
    .line_ctrl (line_ctrl),
    .cfg       (cfg)
  );

  uart_frame_build u_build (
    .cfg  (cfg),
    .data (hold_q),
    .bits (frame_bits),
    .len  (frame_len)
  );

  uart_baud_gen #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .div  (div_run),
    .frac (frac_run),
    .tick (tick)
  );

  uart_tx_shifter #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .frame_in  (frame_bits),
    .len_in    (frame_len),
    .div_in    (baud_div),
    .frac_in   (baud_frac),
    .tick      (tick),
    .txd       (txd),
    .busy      (busy),
    .frame_end (frame_end),
    .div_q     (div_run),
    .frac_q    (frac_run)
  );

  // a write is taken only while both flags are set
  assign accept = tx_wr && buf_empty_q;
  assign start  = pending_q && !busy && (|baud_div);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q       <= '0;
      pending_q    <= 1'b0;
      buf_empty_q  <= 1'b1;
      xmit_empty_q <= 1'b1;
      done_q       <= 1'b0;
    end else begin
      done_q <= frame_end;
      if (accept) begin
        hold_q       <= tx_byte;
        pending_q    <= 1'b1;
        buf_empty_q  <= 1'b0;
        xmit_empty_q <= 1'b0;
      end
      if (start) pending_q <= 1'b0;
      if (frame_end) begin
        buf_empty_q  <= 1'b1;
        xmit_empty_q <= 1'b1;
      end
    end
  end

  assign buf_empty  = buf_empty_q;
  assign xmit_empty = xmit_empty_q;
  assign tx_done    = done_q;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic tx_wr,
  input logic txd,
  input logic buf_empty,
  input logic xmit_empty,
  input logic tx_done
);
  assert_idle_high_R10: assert property (@(posedge clk) disable iff (rst)
    xmit_empty |-> txd);

  assert_done_flags_R7: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (buf_empty && xmit_empty));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);

  assert_clear_by_write_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(xmit_empty) |-> $past(tx_wr));

  assert_rise_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(xmit_empty) |-> tx_done);

  assert_stop_high_R4: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> $past(txd));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_wr      (tx_wr),
  .txd        (txd),
  .buf_empty  (buf_empty),
  .xmit_empty (xmit_empty),
  .tx_done    (tx_done)
);

// File: tb/tb_uart_frame_tx.sv
`timescale 1ns/1ps
module tb_uart_frame_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  line_ctrl = 8'h00;
  logic [15:0] baud_div = 16'd0;
  logic [2:0]  baud_frac = 3'd0;
  logic        tx_wr = 1'b0;
  logic [7:0]  tx_byte = 8'h00;
  logic        txd, buf_empty, xmit_empty, tx_done;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  uart_frame_tx dut (
    .clk(clk), .rst(rst), .line_ctrl(line_ctrl), .baud_div(baud_div),
    .baud_frac(baud_frac), .tx_wr(tx_wr), .tx_byte(tx_byte), .txd(txd),
    .buf_empty(buf_empty), .xmit_empty(xmit_empty), .tx_done(tx_done)
  );

  // {line_ctrl, divisor, fraction, byte}
  localparam logic [34:0] VEC [6] = '{
    {8'h03, 16'd1, 3'd0, 8'hA5},
    {8'h00, 16'd1, 3'd3, 8'h1B},
    {8'h2B, 16'd2, 3'd7, 8'h37},
    {8'h23, 16'd1, 3'd1, 8'h37},
    {8'h06, 16'd1, 3'd5, 8'h5A},
    {8'h2D, 16'd3, 3'd2, 8'h2C}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected frame: [11:0] bits in send order, [15:12] bit count
  function automatic logic [15:0] exp_frame(input logic [7:0] lc, input logic [7:0] d);
    logic [11:0] b;
    int nd, pos;
    logic p;
    nd = int'(lc[1:0]) + 5;
    b = '1;
    b[0] = 1'b0;
    for (int i = 0; i < nd; i++) b[1 + i] = d[i];
    p = ^(d & 8'((9'd1 << nd) - 9'd1));
    pos = 1 + nd;
    if (lc[5]) begin
      b[pos] = lc[3] ? p : ~p;
      pos++;
    end
    pos += lc[2] ? 2 : 1;
    return {pos[3:0], b};
  endfunction

  task automatic run_frame(input string tag, input logic [7:0] lc, input logic [15:0] dv,
                           input logic [2:0] fr, input logic [7:0] d, input bit do_write,
                           input bit mid_act, input logic [7:0] m_lc, input logic [15:0] m_dv,
                           input logic [2:0] m_fr, input logic [7:0] m_byte);
    logic [15:0] ef;
    int n, p, nd, w, extra;
    string lbl;
    ef = exp_frame(lc, d);
    n = int'(ef[15:12]);
    nd = int'(lc[1:0]) + 5;
    p = 16 * int'(dv) + int'(fr) + 16;
    if (do_write) begin
      @(negedge clk);
      line_ctrl = lc; baud_div = dv; baud_frac = fr; tx_byte = d; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
      check(!buf_empty && !xmit_empty, {tag, " R7 flags clear after write"},
            {30'd0, buf_empty, xmit_empty}, 0);
    end
    w = 0;
    while (txd !== 1'b0 && w < 10) begin
      @(negedge clk);
      w++;
    end
    check(txd === 1'b0, {tag, " R4 start edge"}, txd, 0);
    extra = 0;
    for (int i = 0; i < n; i++) begin
      repeat (((i == 0) ? p / 2 : p) - extra) @(negedge clk);
      extra = 0;
      if (i == 0) lbl = "R4 start bit";
      else if (i <= nd) lbl = "R2 data bit";
      else if (lc[5] && i == nd + 1) lbl = "R3 parity bit";
      else lbl = "R4 stop bit";
      check(txd === ef[i], $sformatf("%s %s %0d", tag, lbl, i), txd, ef[i]);
      if (mid_act && i == 1) begin
        tx_wr = 1'b1; tx_byte = m_byte; line_ctrl = m_lc; baud_div = m_dv; baud_frac = m_fr;
        @(negedge clk);
        tx_wr = 1'b0;
        extra = 1;
      end
    end
    repeat (p - p / 2 - 1) @(negedge clk);
    check(!xmit_empty, {tag, " R5 still sending one cycle before N*P"}, xmit_empty, 0);
    @(negedge clk);
    check(xmit_empty && buf_empty, {tag, " R5 flags set at N*P"}, {30'd0, buf_empty, xmit_empty}, 3);
    check(tx_done === 1'b1, {tag, " R7 done pulse at frame end"}, tx_done, 1);
    @(negedge clk);
    check(tx_done === 1'b0, {tag, " R7 done pulse one cycle"}, tx_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 / R10 reset state
    check(txd === 1'b1, "R1 R10 reset line high", txd, 1);
    check(buf_empty === 1'b1 && xmit_empty === 1'b1, "R1 reset status 0x6",
          {29'd0, xmit_empty, buf_empty, 1'b0}, 6);
    check(tx_done === 1'b0, "R1 reset done low", tx_done, 0);

    foreach (VEC[k]) begin
      run_frame($sformatf("vec%0d", k), VEC[k][34:27], VEC[k][26:11], VEC[k][10:8],
                VEC[k][7:0], 1'b1, 1'b0, 8'h00, 16'd0, 3'd0, 8'h00);
    end

    // R8 + R9: write and new settings mid-frame; current frame keeps old format/timing
    run_frame("R9_old", 8'h03, 16'd1, 3'd0, 8'h0F, 1'b1, 1'b1, 8'h00, 16'd2, 3'd1, 8'hF0);
    bad = 0;
    repeat (3 * 10 * 32) begin
      @(negedge clk);
      if (txd !== 1'b1 || xmit_empty !== 1'b1) bad++;
    end
    check(bad == 0, "R8 R10 mid-frame write sent nothing", bad, 0);
    // R9: next frame uses the settings applied mid-frame
    run_frame("R9_new", 8'h00, 16'd2, 3'd1, 8'h15, 1'b1, 1'b0, 8'h00, 16'd0, 3'd0, 8'h00);

    // R6: zero divisor keeps the line idle and holds the byte
    @(negedge clk);
    line_ctrl = 8'h03; baud_div = 16'd0; baud_frac = 3'd0; tx_byte = 8'h3C; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    bad = 0;
    repeat (300) begin
      @(negedge clk);
      if (txd !== 1'b1 || xmit_empty !== 1'b0) bad++;
    end
    check(bad == 0, "R6 zero divisor sends nothing", bad, 0);
    baud_div = 16'd1;
    run_frame("R6_release", 8'h03, 16'd1, 3'd0, 8'h3C, 1'b0, 1'b0, 8'h00, 16'd0, 3'd0, 8'h00);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule